// File: doc/BRIEF.md
# Set/Clear Interrupt Enable Register Bank

This block holds the interrupt enable state of a set of interrupt sources in a bank of bus-writable registers. There are two kinds of register. Mask registers carry one enable bit per source. Priority registers are cut into fields of `FIELD_W` bits, and a field is "on" when its value is nonzero. Every mask register, and every priority register flagged in `PRIO_DUAL`, answers at two addresses. A write to the first address ORs the data into the register. A write to the second address clears the bits that are set in the data. A priority register with a single address stores the written data directly.

On each write the block compares every field of the addressed register before and after the write. Each field that changed sends a one-cycle pulse to the source that a static mapping input assigns to it. The pulse is an enable pulse when the field's new value is nonzero and a disable pulse when it is zero. The source logic downstream uses these pulses to count its enables. The priority values themselves play no part in arbitration here.

Register r answers its first address at `BASE_ADDR + 8*r` and its second address at `BASE_ADDR + 8*r + 4`. The mask registers come first, then the priority registers. Only the low 29 address bits are compared, so an address that differs only in bits 31..29 reaches the same register.

Top module: `mreg_bank`

## Requirements
- R1: A write to the first address of a two-address register stores the old value OR the write data.
- R2: A write to the second address of a two-address register stores the old value AND NOT the write data.
- R3: A write to the single address of a one-address priority register stores the write data as given.
- R4: Each changed field of the written register raises, one cycle after the write, the pulse of its mapped source. Mask bit b of mask register m maps through `map_mask_id[(m*DATA_W+b)*ID_W +: ID_W]`. Field f, bits `[f*FIELD_W +: FIELD_W]`, of priority register p maps through `map_prio_id[(p*NFLD+f)*ID_W +: ID_W]`. The pulse is `src_en_pulse[id]` if the new field value is nonzero and `src_dis_pulse[id]` if it is zero.
- R5: A field whose value is the same before and after a write produces no pulse.
- R6: A field mapped to source ID 0 never produces a pulse; bit 0 of both pulse outputs stays low.
- R7: Address bits 31..29 are ignored, so every alias of a register address reads and writes the same register.
- R8: A read at either address of a register returns its stored value on `bus_rdata` one cycle later. `bus_rdata` keeps that value until the next read.
- R9: A write to an unmapped address changes no register and raises no pulse. A read from an unmapped address returns zero. The second address of a one-address priority register counts as unmapped.
- R10: If two changed fields of one write map to the same source, the less significant field decides which pulse that source gets. A source never receives both pulses in the same cycle.
- R11: Reset clears every register, both pulse outputs and `bus_rdata`.
- R12: Pulses last exactly one cycle and appear only in the cycle after a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | DATA_W (16) | Write data |
| bus_rdata | output | DATA_W (16) | Registered read data |
| map_mask_id | input | N_MASK*DATA_W*ID_W (128) | Source ID for each mask register bit |
| map_prio_id | input | N_PRIO*NFLD*ID_W (32) | Source ID for each priority field |
| src_en_pulse | output | N_SRC (16) | One-cycle enable pulse per source |
| src_dis_pulse | output | N_SRC (16) | One-cycle disable pulse per source |

## Verification
The hardest case to reach is one write that flips two fields mapped to the same source in opposite directions. On a two-address register this cannot happen, because one write only sets or only clears. The bench therefore maps the top and bottom fields of the one-address priority register to the same source. It then writes values that turn the top field off while turning the bottom field on, and the other way round. The bench also reaches registers through their upper-bit aliases. It writes the unmapped second address of the one-address register and then reads the register back to show that nothing moved.

// File: rtl/mreg_pkg.sv
package mreg_pkg;
    // number of low address bits that select a register
    localparam int ADDR_MATCH_W = 29;
    // byte distance between consecutive registers
    localparam int REG_STRIDE   = 8;
    // offset of the clearing alias from the setting alias
    localparam int CLR_OFFSET   = 4;

    function automatic int field_count(input int reg_w, input int fld_w);
        return reg_w / fld_w;
    endfunction
endpackage

// File: rtl/mreg_slot.sv
module mreg_slot #(
    parameter int DATA_W  = 16,
    parameter int FIELD_W = 4,
    parameter bit DUAL    = 1'b1,
    localparam int NF     = DATA_W / FIELD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_set,
    input  logic              wr_clr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] val_q,
    output logic [NF-1:0]     fld_chg,
    output logic [NF-1:0]     fld_on
);
    logic [DATA_W-1:0] val_d;

    always_comb begin
        val_d = val_q;
        if (wr_set) begin
            if (DUAL) val_d = val_q | wdata;
            else      val_d = wdata;
        end else if (wr_clr && DUAL) begin
            val_d = val_q & ~wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) val_q <= '0;
        else        val_q <= val_d;
    end

    for (genvar f = 0; f < NF; f++) begin : g_fld
        assign fld_chg[f] = (val_q[f*FIELD_W +: FIELD_W] != val_d[f*FIELD_W +: FIELD_W]);
        assign fld_on[f]  = |val_d[f*FIELD_W +: FIELD_W];
    end
endmodule

// File: rtl/mreg_router.sv
module mreg_router #(
    parameter int TOT   = 40,
    parameter int ID_W  = 4,
    parameter int N_SRC = 16
) (
    input  logic [TOT-1:0]      chg,
    input  logic [TOT-1:0]      on,
    input  logic [TOT*ID_W-1:0] ids,
    output logic [N_SRC-1:0]    en,
    output logic [N_SRC-1:0]    dis
);
    // index 0 is handled first, a later index overrides an earlier one
    always_comb begin
        int idx;
        en  = '0;
        dis = '0;
        for (int g = 0; g < TOT; g++) begin
            idx = int'(ids[g*ID_W +: ID_W]);
            if (chg[g] && idx != 0 && idx < N_SRC) begin
                en[idx]  = on[g];
                dis[idx] = !on[g];
            end
        end
    end
endmodule

// File: rtl/mreg_bank.sv
module mreg_bank #(
    parameter int          DATA_W    = 16,
    parameter int          FIELD_W   = 4,
    parameter int          N_MASK    = 2,
    parameter int          N_PRIO    = 2,
    parameter logic [1:0]  PRIO_DUAL = 2'b10,
    parameter int          N_SRC     = 16,
    parameter int          ID_W      = 4,
    parameter logic [31:0] BASE_ADDR = 32'h0000_0100,
    localparam int         NFLD      = DATA_W / FIELD_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bus_wr,
    input  logic                          bus_rd,
    input  logic [31:0]                   bus_addr,
    input  logic [DATA_W-1:0]             bus_wdata,
    output logic [DATA_W-1:0]             bus_rdata,
    input  logic [N_MASK*DATA_W*ID_W-1:0] map_mask_id,
    input  logic [N_PRIO*NFLD*ID_W-1:0]   map_prio_id,
    output logic [N_SRC-1:0]              src_en_pulse,
    output logic [N_SRC-1:0]              src_dis_pulse
);
    import mreg_pkg::*;

    localparam int N_REG  = N_MASK + N_PRIO;
    localparam int MW     = ADDR_MATCH_W;
    localparam int P_NF   = field_count(DATA_W, FIELD_W);
    localparam int TOT    = N_MASK * DATA_W + N_PRIO * P_NF;
    localparam int PRIO_G = N_MASK * DATA_W;

    typedef struct packed {
        logic [N_SRC-1:0]  en;
        logic [N_SRC-1:0]  dis;
        logic [DATA_W-1:0] rdata;
    } state_t;

    state_t s_d, s_q;

    logic [N_REG-1:0]  hit_set, hit_clr;
    logic [DATA_W-1:0] reg_val [N_REG];
    logic [TOT-1:0]      all_chg, all_on;
    logic [TOT*ID_W-1:0] all_id;
    logic [N_SRC-1:0]    r_en, r_dis;
    logic [DATA_W-1:0]   rd_mux;

    // address decode for every register
    for (genvar r = 0; r < N_REG; r++) begin : g_dec
        localparam logic [MW-1:0] A_SET = BASE_ADDR[MW-1:0] + MW'(r * REG_STRIDE);
        localparam logic [MW-1:0] A_CLR = A_SET + MW'(CLR_OFFSET);
        localparam bit HAS_CLR = (r < N_MASK) ? 1'b1 : PRIO_DUAL[r - N_MASK];
        assign hit_set[r] = (bus_addr[MW-1:0] == A_SET);
        assign hit_clr[r] = HAS_CLR && (bus_addr[MW-1:0] == A_CLR);
    end

    // mask registers: one bit per source
    for (genvar m = 0; m < N_MASK; m++) begin : g_mask
        logic [DATA_W-1:0] chg_m, on_m;
        mreg_slot #(.DATA_W(DATA_W), .FIELD_W(1), .DUAL(1'b1)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_set  (bus_wr && hit_set[m]),
            .wr_clr  (bus_wr && hit_clr[m]),
            .wdata   (bus_wdata),
            .val_q   (reg_val[m]),
            .fld_chg (chg_m),
            .fld_on  (on_m)
        );
        for (genvar b = 0; b < DATA_W; b++) begin : g_bit
            localparam int G = m * DATA_W + (DATA_W - 1 - b);
            assign all_chg[G]             = chg_m[b];
            assign all_on[G]              = on_m[b];
            assign all_id[G*ID_W +: ID_W] = map_mask_id[(m*DATA_W + b)*ID_W +: ID_W];
        end
    end

    // priority registers: FIELD_W-bit fields
    for (genvar p = 0; p < N_PRIO; p++) begin : g_prio
        logic [P_NF-1:0] chg_p, on_p;
        mreg_slot #(.DATA_W(DATA_W), .FIELD_W(FIELD_W), .DUAL(PRIO_DUAL[p])) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_set  (bus_wr && hit_set[N_MASK + p]),
            .wr_clr  (bus_wr && hit_clr[N_MASK + p]),
            .wdata   (bus_wdata),
            .val_q   (reg_val[N_MASK + p]),
            .fld_chg (chg_p),
            .fld_on  (on_p)
        );
        for (genvar f = 0; f < P_NF; f++) begin : g_f
            localparam int G = PRIO_G + p * P_NF + (P_NF - 1 - f);
            assign all_chg[G]             = chg_p[f];
            assign all_on[G]              = on_p[f];
            assign all_id[G*ID_W +: ID_W] = map_prio_id[(p*P_NF + f)*ID_W +: ID_W];
        end
    end

    mreg_router #(.TOT(TOT), .ID_W(ID_W), .N_SRC(N_SRC)) u_router (
        .chg (all_chg),
        .on  (all_on),
        .ids (all_id),
        .en  (r_en),
        .dis (r_dis)
    );

    always_comb begin
        rd_mux = '0;
        for (int r = 0; r < N_REG; r++) begin
            if (hit_set[r] || hit_clr[r]) rd_mux = rd_mux | reg_val[r];
        end
    end

    always_comb begin
        s_d       = s_q;
        s_d.en    = r_en;
        s_d.dis   = r_dis;
        if (bus_rd) s_d.rdata = rd_mux;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign src_en_pulse  = s_q.en;
    assign src_dis_pulse = s_q.dis;
    assign bus_rdata     = s_q.rdata;
endmodule

// File: rtl/mreg_bank_chk.sv
module mreg_bank_chk #(
    parameter int N_SRC  = 16,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [N_SRC-1:0]  src_en_pulse,
    input logic [N_SRC-1:0]  src_dis_pulse
);
    // R12
    pulse_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|src_en_pulse) || (|src_dis_pulse)) |-> $past(bus_wr));

    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> (src_en_pulse == '0 && src_dis_pulse == '0));

    // R10
    no_dual_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_en_pulse & src_dis_pulse) == '0);

    // R6
    rsvd_id_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !src_en_pulse[0] && !src_dis_pulse[0]);

    // R8
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
endmodule

bind mreg_bank mreg_bank_chk #(.N_SRC(N_SRC), .DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_wr        (bus_wr),
    .bus_rd        (bus_rd),
    .bus_rdata     (bus_rdata),
    .src_en_pulse  (src_en_pulse),
    .src_dis_pulse (src_dis_pulse)
);

// File: tb/mreg_bank_tb.sv
module mreg_bank_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [127:0] map_mask_id;
    logic [31:0]  map_prio_id;
    logic [15:0]  src_en_pulse, src_dis_pulse;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    mreg_bank u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .map_mask_id(map_mask_id), .map_prio_id(map_prio_id),
        .src_en_pulse(src_en_pulse), .src_dis_pulse(src_dis_pulse)
    );

    // mask0 bit b -> source b (bit 0 reserved); mask1 bit 0 -> source 7, rest 0
    // prio0 fields f3..f0 -> 11,10,9,11 ; prio1 fields f3..f0 -> 12,0,13,12
    initial begin
        map_mask_id = '0;
        for (int b = 0; b < 16; b++) map_mask_id[b*4 +: 4] = 4'(b);
        map_mask_id[64 +: 4] = 4'd7;
        map_prio_id = {16'hC0DC, 16'hBA9B};
    end

    typedef struct packed {
        logic        wr;
        logic        rd;
        logic [31:0] addr;
        logic [15:0] wdata;
        logic [15:0] en;
        logic [15:0] dis;
        logic [15:0] rdata;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b0, 32'h0000_0100, 16'h0006, 16'h0006, 16'h0000, 16'h0000, 4'd1},  // R1 R4
        '{1'b0, 1'b1, 32'h0000_0104, 16'h0000, 16'h0000, 16'h0000, 16'h0006, 4'd8},  // R8
        '{1'b1, 1'b0, 32'h0000_0100, 16'h0005, 16'h0000, 16'h0000, 16'h0006, 4'd6},  // R6 R5
        '{1'b0, 1'b1, 32'h0000_0100, 16'h0000, 16'h0000, 16'h0000, 16'h0007, 4'd1},  // R1
        '{1'b1, 1'b0, 32'h0000_0104, 16'h0003, 16'h0000, 16'h0002, 16'h0007, 4'd2},  // R2
        '{1'b1, 1'b0, 32'hA000_0108, 16'h0001, 16'h0080, 16'h0000, 16'h0007, 4'd7},  // R7
        '{1'b0, 1'b1, 32'hE000_010C, 16'h0000, 16'h0000, 16'h0000, 16'h0001, 4'd7},  // R7
        '{1'b1, 1'b0, 32'h0000_0110, 16'h3050, 16'h0A00, 16'h0000, 16'h0001, 4'd4},  // R4
        '{1'b1, 1'b0, 32'h0000_0110, 16'h3700, 16'h0400, 16'h0200, 16'h0001, 4'd3},  // R3
        '{1'b0, 1'b1, 32'h0000_0110, 16'h0000, 16'h0000, 16'h0000, 16'h3700, 4'd3},  // R3
        '{1'b1, 1'b0, 32'h0000_0114, 16'hFFFF, 16'h0000, 16'h0000, 16'h3700, 4'd9},  // R9
        '{1'b0, 1'b1, 32'h0000_0114, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 4'd9},  // R9
        '{1'b0, 1'b1, 32'h0000_0110, 16'h0000, 16'h0000, 16'h0000, 16'h3700, 4'd9},  // R9
        '{1'b1, 1'b0, 32'h0000_0118, 16'h1001, 16'h1000, 16'h0000, 16'h3700, 4'd1},  // R1
        '{1'b1, 1'b0, 32'h0000_011C, 16'h0001, 16'h0000, 16'h1000, 16'h3700, 4'd2},  // R2
        '{1'b1, 1'b0, 32'h0000_0118, 16'h0400, 16'h0000, 16'h0000, 16'h3700, 4'd6},  // R6
        '{1'b1, 1'b0, 32'h0000_0110, 16'h0001, 16'h0800, 16'h0400, 16'h3700, 4'd10}, // R10
        '{1'b1, 1'b0, 32'h0000_0110, 16'h2000, 16'h0000, 16'h0800, 16'h3700, 4'd10}, // R10
        '{1'b0, 1'b1, 32'h2000_011C, 16'h0000, 16'h0000, 16'h0000, 16'h1400, 4'd8}   // R8
    };

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v);
        string tag;
        tag = $sformatf("R%0d", v.req);
        @(negedge clk);
        bus_wr = v.wr; bus_rd = v.rd; bus_addr = v.addr; bus_wdata = v.wdata;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        check(tag, "en pulse", src_en_pulse, v.en);
        check(tag, "dis pulse", src_dis_pulse, v.dis);
        check(tag, "rdata", bus_rdata, v.rdata);
        @(negedge clk);
        // R12: pulses gone one cycle later; R8: rdata held
        check("R12", "en after idle", src_en_pulse, 16'h0);
        check("R12", "dis after idle", src_dis_pulse, 16'h0);
        check("R8", "rdata held", bus_rdata, v.rdata);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11", "reset en", src_en_pulse, 16'h0);
        check("R11", "reset dis", src_dis_pulse, 16'h0);
        check("R11", "reset rdata", bus_rdata, 16'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) run_vec(VEC[i]);

        // R11: reset mid-run clears registers and read data
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R11", "rdata in reset", bus_rdata, 16'h0);
        rst_n = 1'b1;
        run_vec('{1'b0, 1'b1, 32'h0000_0110, 16'h0, 16'h0, 16'h0, 16'h0000, 4'd11}); // R11
        run_vec('{1'b0, 1'b1, 32'h0000_0104, 16'h0, 16'h0, 16'h0, 16'h0000, 4'd11}); // R11
        // R5: rewriting an already-set mask bit after reset pulses once, then not again
        run_vec('{1'b1, 1'b0, 32'h0000_0100, 16'h0010, 16'h0010, 16'h0, 16'h0000, 4'd4});
        run_vec('{1'b1, 1'b0, 32'h0000_0100, 16'h0010, 16'h0000, 16'h0, 16'h0000, 4'd5}); // R5

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule